// File: doc/BRIEF.md
# Interrupt Flag and Request Register

This block gathers three event pulses from a clock-calendar core (update-ended, alarm and periodic) into one read-only status byte. It also raises a single interrupt request line. Each event sets its own sticky flag, whether or not the matching interrupt is enabled. Software can therefore poll the flags without taking interrupts.

A summary bit at the top of the byte is high whenever at least one flag is set and its enable is on. The interrupt line follows that summary bit. The enables come from three bits of a mode register that lives outside this block.

A read strobe marks the cycle in which the status byte is read. In that cycle the byte still shows the flags as they stand. On the following clock every flag clears and the request drops. An event that arrives during the read cycle is not lost: it is held in its flag for the next read.

Top module: `irq_flag_unit`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, all flags clear; after that edge `flag_q` reads 0x00 and `irq_o` is low.
- R2: Bit positions in `flag_q` are fixed. Bit 4 is the update-ended flag, bit 5 the alarm flag and bit 6 the periodic flag. The enable inputs are `int_en_i[0]` (update-ended), `int_en_i[1]` (alarm) and `int_en_i[2]` (periodic). A pulse on an event input shows in its flag bit from the clock edge that samples it.
- R3: An event flag sets on its event even when its enable is low.
- R4: A set flag stays set until a read or a reset, whatever happens on the other inputs.
- R5: Bit 7 of `flag_q` is high exactly when some flag in bits 6:4 is set and its enable is high. An enable change acts on bit 7 in the same cycle.
- R6: `irq_o` always equals bit 7 of `flag_q`.
- R7: In a cycle with `flag_rd_i` high, `flag_q` still shows the current flags. After the edge that samples the read, every flag with no event in that cycle is clear, so bit 7 and `irq_o` drop.
- R8: An event that arrives in the same cycle as a read leaves its flag set after that edge.
- R9: Bits 3:0 of `flag_q` always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_upd_i | input | 1 | Update-ended event pulse |
| evt_alm_i | input | 1 | Alarm event pulse |
| evt_per_i | input | 1 | Periodic event pulse |
| int_en_i | input | 3 | Interrupt enables: [0] update-ended, [1] alarm, [2] periodic |
| flag_rd_i | input | 1 | High in the cycle in which the status byte is read |
| flag_q | output | 8 | Status byte: [7] summary request, [6:4] event flags, [3:0] zero |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A flag that is wrongly held or wrongly dropped shows up in its bit of `flag_q` one cycle after the event or read that should have changed it. A wrong summary also shows on `irq_o` in that cycle. Because the summary is combinational on the enables, a bad gating term shows within the same cycle as an enable change. The bench therefore probes enable changes with no clock edge in between. A read that ignores a simultaneous event appears as a missing flag right after the read edge. The bench steps through read-with-event cases for every source.

// File: rtl/irq_flag_pkg.sv
// Package: irq_flag_pkg
// Shared layout constants for the interrupt flag register.
// Assumes three event sources that occupy consecutive bits above a zero field.
package irq_flag_pkg;
    localparam int REG_W    = 8;  // width of the status byte
    localparam int NUM_SRC  = 3;  // number of event sources
    localparam int FLAG_LSB = 4;  // bit of the lowest event flag
    localparam int SUM_BIT  = 7;  // bit of the summary request

    // Index of each source within the flag and enable vectors.
    typedef enum logic [1:0] {
        SRC_UPD = 2'd0,
        SRC_ALM = 2'd1,
        SRC_PER = 2'd2
    } src_idx_e;
endpackage

// File: rtl/irq_event_latch.sv
// Module: irq_event_latch
// One sticky flag per event source. A flag sets on its event pulse.
// A read strobe clears all flags, but an event in the read cycle is kept.
// Assumes the event pulses and the read strobe are synchronous to clk.
module irq_event_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         rd_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_src
        // Purpose: hold flag i, clearing on read unless an event arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[i] <= 1'b0;
            else if (rd_i)
                flag_o[i] <= evt_i[i];
            else if (evt_i[i])
                flag_o[i] <= 1'b1;
        end

        // R2/R3: an event sets its flag regardless of any other input
        p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> flag_o[i]);
        // R4: a set flag survives a cycle with no read
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !rd_i) |=> flag_o[i]);
        // R7: a read with no event clears the flag
        p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && !evt_i[i]) |=> !flag_o[i]);
        // R8: an event during a read is kept
        p_rd_keeps_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && evt_i[i]) |=> flag_o[i]);
    end

    // R1: reset leaves every flag clear
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (flag_o == '0));
endmodule

// File: rtl/irq_summary.sv
// Module: irq_summary
// Combines the flags with their enables into one request bit.
// Assumes flag and enable vectors use the same source order.
module irq_summary #(
    parameter int N = 3
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         req_o
);
    logic [N-1:0] armed;

    // Purpose: mark the sources whose flag is set and whose enable is on.
    always_comb begin
        armed = flag_i & en_i;
    end

    // Purpose: raise the request if any source is armed.
    always_comb begin
        req_o = |armed;
    end
endmodule

// File: rtl/irq_flag_unit.sv
// Module: irq_flag_unit
// Interrupt flag and request register. It packs the sticky event flags and
// the summary request into a status byte and drives the interrupt line.
// Assumes one-cycle event pulses and a one-cycle read strobe, all on clk.
module irq_flag_unit
    import irq_flag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_upd_i,
    input  logic               evt_alm_i,
    input  logic               evt_per_i,
    input  logic [NUM_SRC-1:0] int_en_i,
    input  logic               flag_rd_i,
    output logic [REG_W-1:0]   flag_q,
    output logic               irq_o
);
    localparam int FLAG_MSB = FLAG_LSB + NUM_SRC - 1;

    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] flags;
    logic               sum_req;

    // Purpose: gather the event pulses in source-index order.
    always_comb begin
        evt_vec          = '0;
        evt_vec[SRC_UPD] = evt_upd_i;
        evt_vec[SRC_ALM] = evt_alm_i;
        evt_vec[SRC_PER] = evt_per_i;
    end

    irq_event_latch #(.N(NUM_SRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_vec),
        .rd_i   (flag_rd_i),
        .flag_o (flags)
    );

    irq_summary #(.N(NUM_SRC)) u_sum (
        .flag_i (flags),
        .en_i   (int_en_i),
        .req_o  (sum_req)
    );

    // Purpose: place each field of the status byte at its bit position.
    for (genvar b = 0; b < REG_W; b++) begin : g_byte
        if (b == SUM_BIT) begin : g_sum
            assign flag_q[b] = sum_req;
        end else if (b >= FLAG_LSB && b <= FLAG_MSB) begin : g_flag
            assign flag_q[b] = flags[b - FLAG_LSB];
        end else begin : g_zero
            assign flag_q[b] = 1'b0;
        end
    end

    // Purpose: drive the request line from the summary bit.
    always_comb begin
        irq_o = flag_q[SUM_BIT];
    end

    // R9: the low field of the byte is always zero
    always_comb begin
        p_low_zero_r9: assert (flag_q[FLAG_LSB-1:0] == '0);
    end
    // R5: a request needs at least one flag with its enable set
    p_req_has_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($countones(flags & int_en_i) > 0));
    // R5: any enabled, set flag must raise the summary bit
    p_src_gives_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(flags & int_en_i) > 0) |-> flag_q[SUM_BIT]);
    // R6: the line matches the summary bit
    p_line_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == flag_q[SUM_BIT]);
endmodule

// File: tb/sim_irq_flag_unit.sv
module sim_irq_flag_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_upd_i = 1'b0, evt_alm_i = 1'b0, evt_per_i = 1'b0;
    logic [2:0] int_en_i = 3'b000;
    logic       flag_rd_i = 1'b0;
    logic [7:0] flag_q;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    irq_flag_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .evt_upd_i(evt_upd_i), .evt_alm_i(evt_alm_i), .evt_per_i(evt_per_i),
        .int_en_i(int_en_i), .flag_rd_i(flag_rd_i),
        .flag_q(flag_q), .irq_o(irq_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Vector: {evt[2:0] per,alm,upd ; en[2:0] ; rd ; expected byte ; expected irq}
    localparam int NV = 13;
    localparam logic [15:0] VEC [NV] = '{
        {3'b001, 3'b000, 1'b0, 8'h10, 1'b0},  // R3 set while disabled
        {3'b000, 3'b000, 1'b0, 8'h10, 1'b0},  // R4 held
        {3'b000, 3'b001, 1'b0, 8'h90, 1'b1},  // R5 enable raises bit 7
        {3'b010, 3'b001, 1'b0, 8'hB0, 1'b1},  // R2 alarm in bit 5
        {3'b000, 3'b100, 1'b0, 8'h30, 1'b0},  // R5 wrong enable
        {3'b100, 3'b100, 1'b0, 8'hF0, 1'b1},  // R2 periodic in bit 6
        {3'b000, 3'b000, 1'b1, 8'h00, 1'b0},  // R7 read clears
        {3'b100, 3'b000, 1'b1, 8'h40, 1'b0},  // R8 periodic kept
        {3'b000, 3'b100, 1'b0, 8'hC0, 1'b1},  // R6 line follows
        {3'b000, 3'b100, 1'b1, 8'h00, 1'b0},  // R7 request drops
        {3'b010, 3'b010, 1'b0, 8'hA0, 1'b1},  // R2 alarm
        {3'b010, 3'b010, 1'b1, 8'hA0, 1'b1},  // R8 alarm kept
        {3'b000, 3'b111, 1'b1, 8'h00, 1'b0}   // R7 all clear
    };

    task automatic check(input string req, input logic [7:0] got_b,
                         input logic [7:0] exp_b, input logic got_i,
                         input logic exp_i);
        n_chk++;
        if (got_b !== exp_b || got_i !== exp_i || got_i !== got_b[7]
            || got_b[3:0] !== 4'h0) begin
            n_bad++;
            $display("FAIL %s: flag_q=%h irq=%b expected flag_q=%h irq=%b",
                     req, got_b, got_i, exp_b, exp_i);
        end
    endtask

    task automatic drive(input logic [2:0] evt, input logic [2:0] en,
                         input logic rd);
        evt_upd_i = evt[0];
        evt_alm_i = evt[1];
        evt_per_i = evt[2];
        int_en_i  = en;
        flag_rd_i = rd;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #5 check("R1 reset", flag_q, 8'h00, irq_o, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // Vector walk
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k][15:13], VEC[k][12:10], VEC[k][9]);
            @(posedge clk);
            #5 check($sformatf("R2-vec%0d R5 R7 R8", k), flag_q,
                     VEC[k][8:1], irq_o, VEC[k][0]);
        end

        // R7: the byte keeps its value during the read cycle
        @(negedge clk) drive(3'b011, 3'b010, 1'b0);
        @(negedge clk) drive(3'b000, 3'b010, 1'b1);
        #1 check("R7 pre-clear value", flag_q, 8'hB0, irq_o, 1'b1);
        @(posedge clk);
        #5 check("R7 post-read", flag_q, 8'h00, irq_o, 1'b0);

        // R5/R6: an enable change acts without a clock edge
        @(negedge clk) drive(3'b001, 3'b000, 1'b0);
        @(negedge clk) drive(3'b000, 3'b000, 1'b0);
        #1 check("R5 enable off", flag_q, 8'h10, irq_o, 1'b0);
        int_en_i = 3'b001;
        #1 check("R6 enable on same cycle", flag_q, 8'h90, irq_o, 1'b1);

        // R8: every source at once during a read
        @(negedge clk) drive(3'b111, 3'b000, 1'b1);
        @(posedge clk);
        #5 check("R8 all sources kept", flag_q, 8'h70, irq_o, 1'b0);

        // R4: flags are held through idle cycles
        @(negedge clk) drive(3'b000, 3'b000, 1'b0);
        repeat (3) @(posedge clk);
        #5 check("R4 held idle", flag_q, 8'h70, irq_o, 1'b0);

        // R1: reset in mid-run clears set flags
        @(negedge clk) begin rst_n = 1'b0; int_en_i = 3'b111; end
        @(posedge clk);
        #5 check("R1 mid-run reset", flag_q, 8'h00, irq_o, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #5 check("R9 idle after reset", flag_q, 8'h00, irq_o, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule